// File: doc/BRIEF.md
# Processor Status and Stack Sequencer

This unit owns the flag byte and the 8-bit stack pointer of a small accumulator processor. It carries out the multi-cycle stack sequences that the instruction decoder hands it:
- pushing and pulling the accumulator or the flag byte;
- subroutine call and return;
- return from interrupt;
- the software break.

It also carries out the single-cycle flag set and clear commands and the two transfers between the stack pointer and the X index register.

The decoder starts an operation with a one-cycle `start` strobe and an operation code. Together with the strobe it presents the current PC, accumulator and X values, which the unit latches. The unit then drives a byte-wide memory port. Read data is expected in the same cycle as the address. The stack occupies page 1, so its addresses are page byte 0x01 followed by the stack pointer.

At the end of a sequence the unit raises `done` for one cycle. In that same cycle it presents a new PC, accumulator or X value together with its load qualifier. The cycle that carries the strobe counts as the first cycle of the operation. A strobe that arrives while a sequence is running is ignored.

Top module: `status_stack_unit`

## Requirements
- R1: After reset the flag byte reads 0x24 (I set, bit 5 set, all else clear), the stack pointer is 0xFF, and `done`, `busy` and `wr_en` are low.
- R2: The flag byte places N at bit 7, V at 6, D at 3, I at 2, Z at 1 and C at 0. Bit 5 always reads 1 and bit 4 always reads 0.
- R3: Codes 1 to 7 each finish in the strobe cycle (`done` high, `busy` low) and change only one flag: 1 clears C, 2 clears D, 3 clears I, 4 clears V, 5 sets C, 6 sets D, 7 sets I.
- R4: Code 8 loads the stack pointer from `x_in` in one cycle and leaves every flag unchanged. Code 9 presents the stack pointer on `x_out` with `x_load` in its single cycle and updates N and Z from it.
- R5: Code 10 (push A) and code 11 (push flags) take 3 cycles. Each makes one write at 0x0100+SP and then decrements SP. The pushed flag byte has bit 5 set and bit 4 clear.
- R6: Code 12 (pull A) takes 4 cycles. It increments SP, reads 0x0100+SP, presents the byte on `a_out` with `a_load`, and updates N and Z only.
- R7: Code 13 (pull flags) takes 4 cycles. It increments SP and replaces N, V, D, I, Z and C from the byte read; bits 5 and 4 of that byte are ignored.
- R8: Code 14 (call) takes 6 cycles. It reads the target low byte at PC+1 and the high byte at PC+2. It pushes PC+2, high byte first, so SP drops by 2, and presents the target on `pc_out` with `pc_load`.
- R9: Code 15 (return) takes 6 cycles. It pulls the low byte and then the high byte, and presents that address plus 1 on `pc_out`, wrapping at 16 bits.
- R10: Code 16 (return from interrupt) takes 6 cycles. It pulls the flag byte, then the PC low byte, then the PC high byte. It restores every flag and presents the pulled address unchanged on `pc_out`.
- R11: Code 17 (break) takes 7 cycles. It pushes PC+2 high byte, then low byte, then the flag byte with bit 4 set, and it sets I. It presents the vector read from 0xFFFE (low byte) and 0xFFFF (high byte) on `pc_out`.
- R12: `done` is high only in the last cycle of an operation. `busy` is high from the cycle after the strobe through the last cycle. A strobe that arrives while `busy` is high has no effect.
- R13: The stack pointer wraps modulo 256, so stack traffic stays inside page 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 5 | Operation code, sampled with `start` |
| pc_in | input | 16 | Current PC, latched at the strobe |
| a_in | input | 8 | Accumulator value, latched at the strobe |
| x_in | input | 8 | X register value for the stack pointer load |
| rd_data | input | 8 | Memory read data, valid in the same cycle as `mem_addr` |
| mem_addr | output | 16 | Memory address |
| wr_data | output | 8 | Memory write data |
| wr_en | output | 1 | Memory write strobe |
| pc_out | output | 16 | New PC value |
| pc_load | output | 1 | `pc_out` is valid this cycle |
| a_out | output | 8 | New accumulator value |
| a_load | output | 1 | `a_out` is valid this cycle |
| x_out | output | 8 | New X value |
| x_load | output | 1 | `x_out` is valid this cycle |
| done | output | 1 | Last cycle of an operation |
| busy | output | 1 | A multi-cycle sequence is in progress |
| status | output | 8 | Flag byte |

## Verification
The assertions assume three things about the inputs. First, memory answers a read combinationally in the cycle that carries the address. Second, `pc_in` and `a_in` matter only in the strobe cycle. Third, the decoder sends no unused operation codes.

The bench models memory as a combinational page-1 array. Every other address returns a byte computed from the address itself. It raises `start` for exactly one cycle per operation and uses only codes 1 to 17. The one deliberate exception is a second strobe placed inside a running push, which checks that it is ignored.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int DW  = 8;
    localparam int AW  = 16;
    localparam int OPW = 5;
    localparam int STW = 3;

    localparam int BIT_N = 7;
    localparam int BIT_V = 6;
    localparam int BIT_U = 5;
    localparam int BIT_B = 4;
    localparam int BIT_D = 3;
    localparam int BIT_I = 2;
    localparam int BIT_Z = 1;
    localparam int BIT_C = 0;

    localparam logic [DW-1:0] STORED_MASK = 8'hCF;

    typedef enum logic [OPW-1:0] {
        CMD_NONE   = 5'd0,
        CMD_CLR_C  = 5'd1,
        CMD_CLR_D  = 5'd2,
        CMD_CLR_I  = 5'd3,
        CMD_CLR_V  = 5'd4,
        CMD_SET_C  = 5'd5,
        CMD_SET_D  = 5'd6,
        CMD_SET_I  = 5'd7,
        CMD_X2SP   = 5'd8,
        CMD_SP2X   = 5'd9,
        CMD_PUSH_A = 5'd10,
        CMD_PUSH_F = 5'd11,
        CMD_PULL_A = 5'd12,
        CMD_PULL_F = 5'd13,
        CMD_CALL   = 5'd14,
        CMD_RET    = 5'd15,
        CMD_IRET   = 5'd16,
        CMD_BREAK  = 5'd17
    } cmd_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_INC,
        SP_DEC,
        SP_LOAD
    } sp_cmd_e;

    typedef struct packed {
        logic          ld_nz;
        logic [DW-1:0] nz_src;
        logic          ld_all;
        logic [DW-1:0] all_src;
        logic [DW-1:0] set_m;
        logic [DW-1:0] clr_m;
    } flag_upd_t;

    function automatic logic [DW-1:0] bit_of(input int pos);
        return DW'(1) << pos;
    endfunction

    // index of the final busy step; zero marks a single-cycle command
    function automatic logic [STW-1:0] last_step(input cmd_e c);
        case (c)
            CMD_PUSH_A, CMD_PUSH_F:        return STW'(2);
            CMD_PULL_A, CMD_PULL_F:        return STW'(3);
            CMD_CALL, CMD_RET, CMD_IRET:   return STW'(5);
            CMD_BREAK:                     return STW'(6);
            default:                       return STW'(0);
        endcase
    endfunction

    function automatic logic is_seq(input cmd_e c);
        return last_step(c) != STW'(0);
    endfunction

endpackage

// File: rtl/psq_status_reg.sv
module psq_status_reg
    import psq_pkg::*;
#(
    parameter logic RESET_I = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  flag_upd_t     upd,
    output logic [DW-1:0] status
);

    logic [DW-1:0] flags_q;
    logic [DW-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (upd.ld_all) begin
            flags_d = upd.all_src & STORED_MASK;
        end
        if (upd.ld_nz) begin
            flags_d[BIT_N] = upd.nz_src[DW-1];
            flags_d[BIT_Z] = (upd.nz_src == '0);
        end
        flags_d = ((flags_d & ~upd.clr_m) | upd.set_m) & STORED_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q        <= '0;
            flags_q[BIT_I] <= RESET_I;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign status = flags_q | bit_of(BIT_U);

    assert_quiet_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (upd == '0) |=> $stable(status));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (upd.ld_nz && !upd.ld_all && upd.set_m == '0 && upd.clr_m == '0)
        |=> (status[BIT_Z] == ($past(upd.nz_src) == '0)));

endmodule

// File: rtl/psq_stack_ptr.sv
module psq_stack_ptr
    import psq_pkg::*;
#(
    parameter logic [DW-1:0] SP_RESET = 8'hFF
) (
    input  logic          clk,
    input  logic          rst,
    input  sp_cmd_e       cmd,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] sp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_RESET;
        end else begin
            case (cmd)
                SP_INC:  sp <= sp + DW'(1);
                SP_DEC:  sp <= sp - DW'(1);
                SP_LOAD: sp <= ld_val;
                default: sp <= sp;
            endcase
        end
    end

    assert_sp_step_R13: assert property (@(posedge clk) disable iff (rst)
        (cmd != SP_LOAD) |=> (sp == $past(sp) ||
                              sp == DW'($past(sp) + DW'(1)) ||
                              sp == DW'($past(sp) - DW'(1))));

    assert_sp_load_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == SP_LOAD) |=> (sp == $past(ld_val)));

endmodule

// File: rtl/psq_seq.sv
module psq_seq
    import psq_pkg::*;
#(
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [AW-1:0]  pc_in,
    input  logic [DW-1:0]  a_in,
    input  logic [DW-1:0]  rd_data,
    input  logic [DW-1:0]  sp,
    input  logic [DW-1:0]  status,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  wr_data,
    output logic           wr_en,
    output sp_cmd_e        sp_cmd,
    output flag_upd_t      upd,
    output logic [AW-1:0]  pc_out,
    output logic           pc_load,
    output logic [DW-1:0]  a_out,
    output logic           a_load,
    output logic [DW-1:0]  x_out,
    output logic           x_load,
    output logic           done,
    output logic           busy
);

    cmd_e           op_in;
    cmd_e           op_q;
    logic           busy_q;
    logic [STW-1:0] step_q;
    logic [AW-1:0]  pc_q;
    logic [DW-1:0]  a_q;
    logic [DW-1:0]  lo_q;
    logic           cap_lo;
    logic           single;
    logic           launch;
    logic           last;
    logic [AW-1:0]  stk_addr;
    logic [AW-1:0]  pc_ret;

    assign op_in    = cmd_e'(op);
    assign single   = start && !busy_q && !is_seq(op_in);
    assign launch   = start && !busy_q &&  is_seq(op_in);
    assign last     = busy_q && (step_q == last_step(op_q));
    assign stk_addr = {STACK_PAGE, sp};
    assign pc_ret   = pc_q + AW'(2);
    assign busy     = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            op_q   <= CMD_NONE;
            step_q <= '0;
            pc_q   <= '0;
            a_q    <= '0;
            lo_q   <= '0;
        end else begin
            if (launch) begin
                busy_q <= 1'b1;
                op_q   <= op_in;
                step_q <= STW'(1);
                pc_q   <= pc_in;
                a_q    <= a_in;
            end else if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + STW'(1);
                end
            end
            if (cap_lo) begin
                lo_q <= rd_data;
            end
        end
    end

    always_comb begin
        mem_addr = stk_addr;
        wr_data  = '0;
        wr_en    = 1'b0;
        sp_cmd   = SP_HOLD;
        upd      = '0;
        pc_out   = '0;
        pc_load  = 1'b0;
        a_out    = '0;
        a_load   = 1'b0;
        x_out    = '0;
        x_load   = 1'b0;
        done     = 1'b0;
        cap_lo   = 1'b0;

        if (single) begin
            done = 1'b1;
            case (op_in)
                CMD_CLR_C: upd.clr_m = bit_of(BIT_C);
                CMD_CLR_D: upd.clr_m = bit_of(BIT_D);
                CMD_CLR_I: upd.clr_m = bit_of(BIT_I);
                CMD_CLR_V: upd.clr_m = bit_of(BIT_V);
                CMD_SET_C: upd.set_m = bit_of(BIT_C);
                CMD_SET_D: upd.set_m = bit_of(BIT_D);
                CMD_SET_I: upd.set_m = bit_of(BIT_I);
                CMD_X2SP:  sp_cmd    = SP_LOAD;
                CMD_SP2X: begin
                    x_out      = sp;
                    x_load     = 1'b1;
                    upd.ld_nz  = 1'b1;
                    upd.nz_src = sp;
                end
                default: ;
            endcase
        end else if (busy_q) begin
            done = last;
            case (op_q)
                CMD_PUSH_A, CMD_PUSH_F: begin
                    if (step_q == STW'(2)) begin
                        wr_en   = 1'b1;
                        wr_data = (op_q == CMD_PUSH_A) ? a_q : status;
                        sp_cmd  = SP_DEC;
                    end
                end
                CMD_PULL_A, CMD_PULL_F: begin
                    if (step_q == STW'(2)) begin
                        sp_cmd = SP_INC;
                    end else if (step_q == STW'(3)) begin
                        if (op_q == CMD_PULL_A) begin
                            a_out      = rd_data;
                            a_load     = 1'b1;
                            upd.ld_nz  = 1'b1;
                            upd.nz_src = rd_data;
                        end else begin
                            upd.ld_all  = 1'b1;
                            upd.all_src = rd_data;
                        end
                    end
                end
                CMD_CALL: begin
                    case (step_q)
                        STW'(1): begin
                            mem_addr = pc_q + AW'(1);
                            cap_lo   = 1'b1;
                        end
                        STW'(3): begin
                            wr_en   = 1'b1;
                            wr_data = pc_ret[AW-1:DW];
                            sp_cmd  = SP_DEC;
                        end
                        STW'(4): begin
                            wr_en   = 1'b1;
                            wr_data = pc_ret[DW-1:0];
                            sp_cmd  = SP_DEC;
                        end
                        STW'(5): begin
                            mem_addr = pc_ret;
                            pc_out   = {rd_data, lo_q};
                            pc_load  = 1'b1;
                        end
                        default: ;
                    endcase
                end
                CMD_RET: begin
                    case (step_q)
                        STW'(3): sp_cmd = SP_INC;
                        STW'(4): begin
                            cap_lo = 1'b1;
                            sp_cmd = SP_INC;
                        end
                        STW'(5): begin
                            pc_out  = {rd_data, lo_q} + AW'(1);
                            pc_load = 1'b1;
                        end
                        default: ;
                    endcase
                end
                CMD_IRET: begin
                    case (step_q)
                        STW'(2): sp_cmd = SP_INC;
                        STW'(3): begin
                            upd.ld_all  = 1'b1;
                            upd.all_src = rd_data;
                            sp_cmd      = SP_INC;
                        end
                        STW'(4): begin
                            cap_lo = 1'b1;
                            sp_cmd = SP_INC;
                        end
                        STW'(5): begin
                            pc_out  = {rd_data, lo_q};
                            pc_load = 1'b1;
                        end
                        default: ;
                    endcase
                end
                CMD_BREAK: begin
                    case (step_q)
                        STW'(2): begin
                            wr_en   = 1'b1;
                            wr_data = pc_ret[AW-1:DW];
                            sp_cmd  = SP_DEC;
                        end
                        STW'(3): begin
                            wr_en   = 1'b1;
                            wr_data = pc_ret[DW-1:0];
                            sp_cmd  = SP_DEC;
                        end
                        STW'(4): begin
                            wr_en     = 1'b1;
                            wr_data   = status | bit_of(BIT_B);
                            sp_cmd    = SP_DEC;
                            upd.set_m = bit_of(BIT_I);
                        end
                        STW'(5): begin
                            mem_addr = IRQ_VEC;
                            cap_lo   = 1'b1;
                        end
                        STW'(6): begin
                            mem_addr = IRQ_VEC + AW'(1);
                            pc_out   = {rd_data, lo_q};
                            pc_load  = 1'b1;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assert_push_page_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    assert_stay_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done) |=> busy_q);

    assert_done_releases_R12: assert property (@(posedge clk) disable iff (rst)
        (busy_q && done) |=> !busy_q);

    assert_load_in_done_R12: assert property (@(posedge clk) disable iff (rst)
        (pc_load || a_load || x_load) |-> done);

endmodule

// File: rtl/status_stack_unit.sv
module status_stack_unit
    import psq_pkg::*;
#(
    parameter logic [DW-1:0] SP_RESET   = 8'hFF,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE,
    parameter logic          RESET_I    = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [AW-1:0]  pc_in,
    input  logic [DW-1:0]  a_in,
    input  logic [DW-1:0]  x_in,
    input  logic [DW-1:0]  rd_data,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  wr_data,
    output logic           wr_en,
    output logic [AW-1:0]  pc_out,
    output logic           pc_load,
    output logic [DW-1:0]  a_out,
    output logic           a_load,
    output logic [DW-1:0]  x_out,
    output logic           x_load,
    output logic           done,
    output logic           busy,
    output logic [DW-1:0]  status
);

    sp_cmd_e       sp_cmd;
    flag_upd_t     upd;
    logic [DW-1:0] sp;

    psq_status_reg #(
        .RESET_I (RESET_I)
    ) u_flags (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .status (status)
    );

    psq_stack_ptr #(
        .SP_RESET (SP_RESET)
    ) u_sp (
        .clk    (clk),
        .rst    (rst),
        .cmd    (sp_cmd),
        .ld_val (x_in),
        .sp     (sp)
    );

    psq_seq #(
        .STACK_PAGE (STACK_PAGE),
        .IRQ_VEC    (IRQ_VEC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op       (op),
        .pc_in    (pc_in),
        .a_in     (a_in),
        .rd_data  (rd_data),
        .sp       (sp),
        .status   (status),
        .mem_addr (mem_addr),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .sp_cmd   (sp_cmd),
        .upd      (upd),
        .pc_out   (pc_out),
        .pc_load  (pc_load),
        .a_out    (a_out),
        .a_load   (a_load),
        .x_out    (x_out),
        .x_load   (x_load),
        .done     (done),
        .busy     (busy)
    );

endmodule

// File: tb/sim_status_stack_unit.sv
`timescale 1ns/1ps
module sim_status_stack_unit;

    localparam logic [4:0] K_X2SP = 5'd8,  K_SP2X = 5'd9,  K_PUSHA = 5'd10, K_PUSHF = 5'd11;
    localparam logic [4:0] K_PULLA = 5'd12, K_PULLF = 5'd13, K_CALL = 5'd14, K_RET = 5'd15;
    localparam logic [4:0] K_IRET = 5'd16, K_BRK = 5'd17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  op = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  a_in = '0, x_in = '0, rd_data;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  wr_data, a_out, x_out, status;
    logic        wr_en, pc_load, a_load, x_load, done, busy;

    int vec = 0, fails = 0, wl_n = 0;
    logic [7:0]  stk [256];
    logic [15:0] wl_a [16];
    logic [7:0]  wl_d [16];
    int          c_cyc, c_wbase;
    logic [15:0] c_pc;
    logic [7:0]  c_a, c_x;
    logic        c_pcld, c_ald, c_xld;
    logic [7:0]  exp_p, exp_sp;

    always #4 clk = ~clk;

    status_stack_unit u0 (.*);

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] with_nz(input logic [7:0] p, input logic [7:0] v);
        return (p & 8'h7D) | {v[7], 7'b0} | {6'b0, v == 8'h00, 1'b0};
    endfunction

    function automatic logic [7:0] single_exp(input int k, input logic [7:0] p);
        case (k)
            1: return p & ~8'h01;
            2: return p & ~8'h08;
            3: return p & ~8'h04;
            4: return p & ~8'h40;
            5: return p | 8'h01;
            6: return p | 8'h08;
            default: return p | 8'h04;
        endcase
    endfunction

    always_comb rd_data = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : pat(mem_addr);

    always @(posedge clk) begin
        if (wr_en) begin
            if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= wr_data;
            wl_a[wl_n % 16] <= mem_addr;
            wl_d[wl_n % 16] <= wr_data;
            wl_n <= wl_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vec++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [4:0] o, input logic [15:0] pc, input logic [7:0] a, input logic [7:0] x);
        @(negedge clk);
        c_wbase = wl_n;
        start = 1'b1; op = o; pc_in = pc; a_in = a; x_in = x; c_cyc = 1;
        #1;
        while (!done && c_cyc < 16) begin
            @(negedge clk); start = 1'b0; c_cyc++; #1;
        end
        c_pc = pc_out; c_pcld = pc_load; c_a = a_out; c_ald = a_load; c_x = x_out; c_xld = x_load;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic read_sp(input string req, input logic [7:0] want);
        do_op(K_SP2X, 16'h0, 8'h0, 8'h0);
        chk(req, "sp via x_out", c_x, want);
        exp_p = with_nz(exp_p, want);
        chk("R4", "sp2x nz flags", status, exp_p);
    endtask

    task automatic set_sp(input logic [7:0] v);
        do_op(K_X2SP, 16'h0, 8'h0, v);
        exp_sp = v;
    endtask

    task automatic pull_flags(input logic [7:0] b);
        stk[8'(exp_sp + 8'd1)] = b;
        do_op(K_PULLF, 16'h0, 8'h0, 8'h0);
        exp_sp = 8'(exp_sp + 8'd1);
        exp_p = (b & 8'hCF) | 8'h20;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset status", status, 8'h24);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset wr_en", wr_en, 0);
        @(negedge clk); rst = 1'b0;
        exp_p = 8'h24;
        read_sp("R1", 8'hFF);
        exp_sp = 8'hFF;

        // flag byte load over every value, then each single-cycle command on it
        for (int s = 0; s < 256; s++) begin
            for (int k = 1; k <= 7; k++) begin
                pull_flags(8'(s));
                chk("R7", "pull flags cycles", c_cyc, 4);
                chk("R2", "pulled flag byte", status, exp_p);
                do_op(5'(k), 16'h0, 8'h0, 8'h0);
                exp_p = single_exp(k, exp_p);
                chk("R3", "single cycles", c_cyc, 1);
                chk("R3", "single flags", status, exp_p);
            end
        end

        // stack pointer transfers
        for (int x = 0; x < 256; x++) begin
            set_sp(8'(x));
            chk("R4", "x2sp cycles", c_cyc, 1);
            chk("R4", "x2sp flags untouched", status, exp_p);
            read_sp("R4", 8'(x));
            chk("R4", "sp2x load", c_xld, 1);
        end

        // pushes across every stack position, including the wrap at zero
        for (int v = 0; v < 256; v++) begin
            set_sp(8'(v));
            if (v % 16 == 0) begin
                do_op(K_PUSHF, 16'h0, 8'h0, 8'h0);
                chk("R5", "push flags data", wl_d[c_wbase % 16], exp_p & 8'hEF);
            end else begin
                do_op(K_PUSHA, 16'h0, 8'(v ^ 8'h3C), 8'h0);
                chk("R5", "push A data", wl_d[c_wbase % 16], 8'(v ^ 8'h3C));
            end
            chk("R5", "push cycles", c_cyc, 3);
            chk("R5", "push write count", wl_n - c_wbase, 1);
            chk("R5", "push address", wl_a[c_wbase % 16], 16'h0100 + 16'(v));
            read_sp("R13", 8'(v - 1));
            exp_sp = 8'(v - 1);
        end

        // pull A over every value
        for (int v = 0; v < 256; v++) begin
            stk[8'(exp_sp + 8'd1)] = 8'(v);
            do_op(K_PULLA, 16'h0, 8'h0, 8'h0);
            exp_sp = 8'(exp_sp + 8'd1);
            exp_p = with_nz(exp_p, 8'(v));
            chk("R6", "pull A cycles", c_cyc, 4);
            chk("R6", "pull A value", {c_ald, c_a}, {1'b1, 8'(v)});
            chk("R6", "pull A flags", status, exp_p);
        end

        // call / return, break / interrupt return
        for (int i = 0; i < 32; i++) begin
            logic [15:0] pc, r;
            logic [7:0]  sp0, pf;
            pc  = (i == 31) ? 16'hFFFE : 16'(i * 2063);
            sp0 = 8'(i * 8);
            r   = 16'(pc + 16'd2);
            set_sp(sp0);
            do_op(K_CALL, pc, 8'h0, 8'h0);
            chk("R8", "call cycles", c_cyc, 6);
            chk("R8", "call target", {c_pcld, c_pc}, {1'b1, pat(16'(pc + 16'd2)), pat(16'(pc + 16'd1))});
            chk("R8", "call writes", wl_n - c_wbase, 2);
            chk("R8", "call hi addr", wl_a[c_wbase % 16], 16'h0100 + 16'(sp0));
            chk("R8", "call hi data", wl_d[c_wbase % 16], r[15:8]);
            chk("R8", "call lo addr", wl_a[(c_wbase + 1) % 16], 16'h0100 + 16'(8'(sp0 - 8'd1)));
            chk("R8", "call lo data", wl_d[(c_wbase + 1) % 16], r[7:0]);
            do_op(K_RET, 16'h0, 8'h0, 8'h0);
            chk("R9", "return cycles", c_cyc, 6);
            chk("R9", "return pc", {c_pcld, c_pc}, {1'b1, 16'(r + 16'd1)});
            read_sp("R9", sp0);
            exp_sp = sp0;

            pull_flags(8'(i * 37));
            pf = exp_p;
            do_op(K_BRK, pc, 8'h0, 8'h0);
            chk("R11", "break cycles", c_cyc, 7);
            chk("R11", "break vector", {c_pcld, c_pc}, {1'b1, pat(16'hFFFF), pat(16'hFFFE)});
            chk("R11", "break writes", wl_n - c_wbase, 3);
            chk("R11", "break hi", {wl_a[c_wbase % 16], wl_d[c_wbase % 16]},
                {16'h0100 + 16'(exp_sp), r[15:8]});
            chk("R11", "break lo", wl_d[(c_wbase + 1) % 16], r[7:0]);
            chk("R11", "break flag byte", {wl_a[(c_wbase + 2) % 16], wl_d[(c_wbase + 2) % 16]},
                {16'h0100 + 16'(8'(exp_sp - 8'd2)), pf | 8'h10});
            chk("R11", "break sets I", status, pf | 8'h04);
            do_op(K_IRET, 16'h0, 8'h0, 8'h0);
            exp_p = pf;
            chk("R10", "iret cycles", c_cyc, 6);
            chk("R10", "iret pc", {c_pcld, c_pc}, {1'b1, r});
            chk("R10", "iret flags", status, pf);
            read_sp("R10", exp_sp);
        end

        // a strobe inside a running push has no effect
        set_sp(8'h80);
        @(negedge clk);
        start = 1'b1; op = K_PUSHA; a_in = 8'h11; #1;
        chk("R12", "busy in strobe cycle", busy, 0);
        @(negedge clk);
        start = 1'b1; op = K_X2SP; x_in = 8'h05; #1;
        chk("R12", "busy in cycle 2", busy, 1);
        chk("R12", "no done in cycle 2", done, 0);
        @(negedge clk);
        start = 1'b0; #1;
        chk("R12", "done in cycle 3", {busy, done}, 2'b11);
        @(negedge clk); #1;
        chk("R12", "idle after done", {busy, done}, 2'b00);
        chk("R12", "stray strobe stack data", stk[8'h80], 8'h11);
        read_sp("R12", 8'h7F);

        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

endmodule